// File: doc/BRIEF.md
# Antenna Dwell-Time Switching Sequencer

The block walks an RF antenna switch through a programmed list of ports. Each port stays selected for a set number of sample periods. The timing follows an external clock that runs at twice the sample rate. That clock is brought into the system clock domain and divided by two, so the dwell counter advances exactly once per sample.

The schedule holds up to 16 entries. Each entry has a 3-bit port number and a 32-bit dwell count. Software stages entries and then commits a length. At commit the block computes the cumulative match points and checks that the schedule is valid. When a match point is reached, the next entry's port is driven. After the last entry the sequence returns to entry 0, and the counter is cleared without losing a sample.

The 3-bit port is spread over five switch control lines. An enable bit gates the sequence. A halt input freezes the counter and is the only window in which configuration writes are accepted. A reset-state pulse rewinds the sequence to entry 0 and keeps the schedule.

Top module: `ant_dwell_seq`

## Requirements
- R1: After reset, sw_ctrl_o is 5'b10000 (the encoding of port 0), active_idx_o is 0, cfg_err_o is 0 and the sequence is disabled.
- R2: The sample step occurs once every two rising edges of ext_clk_i. Every entry, including entry 0 after a wrap, stays active for exactly its dwell count of steps.
- R3: When entry i's cumulative threshold is reached, active_idx_o becomes i+1 and the outputs show that entry's port. After the last entry both return to entry 0.
- R4: Output encoding: sw_ctrl_o[0] and sw_ctrl_o[1] both equal port bit 0, sw_ctrl_o[2] and sw_ctrl_o[3] both equal port bit 1, and sw_ctrl_o[4] is the inverse of port bit 2.
- R5: A valid load while halted sets active_idx_o to 0 and sw_ctrl_o to the encoding of entry 0's port, two clock edges after the load pulse. The counter restarts from 0.
- R6: While halt_i is low, entry writes, load pulses and enable writes are ignored.
- R7: While enable is 0, active_idx_o and sw_ctrl_o hold their values, whatever ext_clk_i does.
- R8: While halt_i is high, the counter and the outputs are frozen.
- R9: A rst_state_i pulse clears the counter and sets active_idx_o to 0 and sw_ctrl_o to entry 0's port on the next edge. The schedule in force is kept.
- R10: A load is rejected when any of these holds: the length is 0 or above 16, a dwell among the first length entries is 0, or the total dwell exceeds 2^32-1. A rejected load sets cfg_err_o and leaves the schedule and outputs unchanged. An accepted load clears cfg_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_clk_i | input | 1 | External clock at twice the sample rate |
| halt_i | input | 1 | Freeze counter; opens configuration window |
| en_wr_i | input | 1 | Enable write strobe |
| en_val_i | input | 1 | Enable value |
| rst_state_i | input | 1 | Rewind sequence to entry 0 |
| wr_i | input | 1 | Staging entry write strobe |
| wr_idx_i | input | 4 | Staging entry index |
| wr_port_i | input | 3 | Port number for the entry |
| wr_dwell_i | input | 32 | Dwell count in samples for the entry |
| load_i | input | 1 | Commit staged entries |
| load_len_i | input | 5 | Number of entries to commit |
| sw_ctrl_o | output | 5 | Switch control lines |
| active_idx_o | output | 4 | Index of the active entry |
| cfg_err_o | output | 1 | Last load was rejected |

## Verification
The sequence is run with a four-entry schedule. Its ports differ in every bit, and its dwells include 1 sample as well as longer runs, so the per-segment lengths show whether a wrap loses or gains a sample. The same schedule is rerun after a reset-state pulse to show that it survives. A two-entry schedule with a first dwell of 2 and a second of 1 then checks that a new commit takes over cleanly. Configuration attempts made while running are checked against a later rewind. Rejected loads (zero length, a zero dwell, an overflowing total) are checked by rewinding afterwards and confirming that the older entry 0 port still appears.

// File: rtl/ads_pkg.sv
package ads_pkg;
  localparam int unsigned PORT_W = 3;
  localparam int unsigned CTRL_W = 5;

  // bit0 -> lines 0,1 ; bit1 -> lines 2,3 ; bit2 inverted -> line 4
  function automatic logic [CTRL_W-1:0] port_to_ctrl(input logic [PORT_W-1:0] p);
    return {~p[2], p[1], p[1], p[0], p[0]};
  endfunction
endpackage

// File: rtl/ads_tick_gen.sv
module ads_tick_gen #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PRESCALE    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_clk_i,
  output logic step_o
);
  localparam int unsigned PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [PS_W-1:0]        div_q;
  logic                   tick;

  assign tick   = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign step_o = tick && (div_q == PS_W'(PRESCALE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      div_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk_i};
      prev_q <= sync_q[SYNC_STAGES-1];
      if (tick) div_q <= (div_q == PS_W'(PRESCALE - 1)) ? '0 : div_q + PS_W'(1);
    end
  end

  // R2: steps come from edge ticks, never back to back
  p_step_spaced_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o);
endmodule

// File: rtl/ads_sched_regs.sv
module ads_sched_regs
  import ads_pkg::*;
#(
  parameter int unsigned MAX_ENTRIES = 16,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned IDX_W       = 4,
  parameter int unsigned LEN_W       = 5
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   halt_i,
  input  logic                                   wr_i,
  input  logic [IDX_W-1:0]                       wr_idx_i,
  input  logic [PORT_W-1:0]                      wr_port_i,
  input  logic [CNT_W-1:0]                       wr_dwell_i,
  input  logic                                   load_i,
  input  logic [LEN_W-1:0]                       load_len_i,
  output logic [MAX_ENTRIES-1:0][PORT_W-1:0]     port_o,
  output logic [MAX_ENTRIES-1:0][CNT_W-1:0]      thr_o,
  output logic [IDX_W-1:0]                       last_o,
  output logic                                   commit_o,
  output logic                                   err_o
);
  logic [MAX_ENTRIES-1:0][PORT_W-1:0] st_port_q;
  logic [MAX_ENTRIES-1:0][CNT_W-1:0]  st_dwell_q;
  logic [MAX_ENTRIES-1:0][CNT_W-1:0]  acc;
  logic [CNT_W:0]                     sum;
  logic                               bad;

  // cumulative thresholds and validity of the staged schedule
  always_comb begin
    sum = '0;
    bad = (load_len_i == '0) || (load_len_i > LEN_W'(MAX_ENTRIES));
    for (int i = 0; i < int'(MAX_ENTRIES); i++) begin
      if (i < int'(load_len_i)) begin
        sum = sum + {1'b0, st_dwell_q[i]};
        if (st_dwell_q[i] == '0) bad = 1'b1;
        if (sum[CNT_W]) bad = 1'b1;
      end
      acc[i] = sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_port_q  <= '0;
      st_dwell_q <= '{default: CNT_W'(1)};
    end else if (halt_i && wr_i && (int'(wr_idx_i) < int'(MAX_ENTRIES))) begin
      st_port_q[wr_idx_i]  <= wr_port_i;
      st_dwell_q[wr_idx_i] <= wr_dwell_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_o   <= '0;
      thr_o    <= '{default: CNT_W'(1)};
      last_o   <= '0;
      commit_o <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      commit_o <= 1'b0;
      if (halt_i && load_i) begin
        if (bad) begin
          err_o <= 1'b1;
        end else begin
          port_o   <= st_port_q;
          thr_o    <= acc;
          last_o   <= IDX_W'(load_len_i - LEN_W'(1));
          commit_o <= 1'b1;
          err_o    <= 1'b0;
        end
      end
    end
  end

  p_reject_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && load_i && load_len_i == '0) |=> (err_o && $stable(last_o) && $stable(thr_o)));
  p_no_commit_running_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halt_i |=> !commit_o);
endmodule

// File: rtl/ads_seq_core.sv
module ads_seq_core
  import ads_pkg::*;
#(
  parameter int unsigned MAX_ENTRIES = 16,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned IDX_W       = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               step_i,
  input  logic                               halt_i,
  input  logic                               en_wr_i,
  input  logic                               en_val_i,
  input  logic                               rst_state_i,
  input  logic                               commit_i,
  input  logic [MAX_ENTRIES-1:0][PORT_W-1:0] port_i,
  input  logic [MAX_ENTRIES-1:0][CNT_W-1:0]  thr_i,
  input  logic [IDX_W-1:0]                   last_i,
  output logic [CTRL_W-1:0]                  ctrl_o,
  output logic [IDX_W-1:0]                   idx_o
);
  logic             en_q;
  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic [IDX_W-1:0] idx_q, nxt_idx;
  logic             run, hit, at_last;

  assign run     = step_i && en_q && !halt_i;
  assign cnt_inc = cnt_q + CNT_W'(1);
  assign hit     = (cnt_inc == thr_i[idx_q]);
  assign at_last = (idx_q == last_i);
  assign nxt_idx = at_last ? '0 : idx_q + IDX_W'(1);
  assign idx_o   = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 en_q <= 1'b0;
    else if (halt_i && en_wr_i)  en_q <= en_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      idx_q  <= '0;
      ctrl_o <= port_to_ctrl('0);
    end else if (commit_i || rst_state_i) begin
      cnt_q  <= '0;
      idx_q  <= '0;
      ctrl_o <= port_to_ctrl(port_i[0]);
    end else if (run) begin
      if (hit) begin
        // wrap clears the counter in the matching step: no lost sample
        cnt_q  <= at_last ? '0 : cnt_inc;
        idx_q  <= nxt_idx;
        ctrl_o <= port_to_ctrl(port_i[nxt_idx]);
      end else begin
        cnt_q <= cnt_inc;
      end
    end
  end

  p_cnt_below_thr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |-> (cnt_q < thr_i[idx_q]));
  p_wrap_to_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && hit && at_last && !commit_i && !rst_state_i) |=> (idx_q == '0 && cnt_q == '0));
  p_ctrl_tracks_idx_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |-> (ctrl_o == port_to_ctrl(port_i[idx_q])));
  p_hold_disabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !commit_i && !rst_state_i) |=> ($stable(idx_q) && $stable(ctrl_o)));
  p_halt_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !commit_i && !rst_state_i) |=> ($stable(cnt_q) && $stable(idx_q)));
  p_rewind_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_state_i |=> (idx_q == '0 && cnt_q == '0));
endmodule

// File: rtl/ant_dwell_seq.sv
module ant_dwell_seq
  import ads_pkg::*;
#(
  parameter int unsigned MAX_ENTRIES = 16,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PRESCALE    = 2,
  localparam int unsigned IDX_W      = $clog2(MAX_ENTRIES),
  localparam int unsigned LEN_W      = $clog2(MAX_ENTRIES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_clk_i,
  input  logic              halt_i,
  input  logic              en_wr_i,
  input  logic              en_val_i,
  input  logic              rst_state_i,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [2:0]        wr_port_i,
  input  logic [CNT_W-1:0]  wr_dwell_i,
  input  logic              load_i,
  input  logic [LEN_W-1:0]  load_len_i,
  output logic [4:0]        sw_ctrl_o,
  output logic [IDX_W-1:0]  active_idx_o,
  output logic              cfg_err_o
);
  logic                               step;
  logic [MAX_ENTRIES-1:0][PORT_W-1:0] act_port;
  logic [MAX_ENTRIES-1:0][CNT_W-1:0]  act_thr;
  logic [IDX_W-1:0]                   act_last;
  logic                               commit;

  ads_tick_gen #(.SYNC_STAGES(SYNC_STAGES), .PRESCALE(PRESCALE)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .ext_clk_i(ext_clk_i), .step_o(step)
  );

  ads_sched_regs #(.MAX_ENTRIES(MAX_ENTRIES), .CNT_W(CNT_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .halt_i(halt_i),
    .wr_i(wr_i), .wr_idx_i(wr_idx_i), .wr_port_i(wr_port_i), .wr_dwell_i(wr_dwell_i),
    .load_i(load_i), .load_len_i(load_len_i),
    .port_o(act_port), .thr_o(act_thr), .last_o(act_last),
    .commit_o(commit), .err_o(cfg_err_o)
  );

  ads_seq_core #(.MAX_ENTRIES(MAX_ENTRIES), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step), .halt_i(halt_i),
    .en_wr_i(en_wr_i), .en_val_i(en_val_i), .rst_state_i(rst_state_i),
    .commit_i(commit), .port_i(act_port), .thr_i(act_thr), .last_i(act_last),
    .ctrl_o(sw_ctrl_o), .idx_o(active_idx_o)
  );

  // R5: a commit always lands on entry 0
  p_commit_entry0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> (active_idx_o == '0));
endmodule

// File: tb/tb_ant_dwell_seq.sv
module tb_ant_dwell_seq;
  localparam int CLK_PERIOD = 10;
  localparam int STEP_CYC   = 8;  // ext clock toggles every 2 cycles -> step every 8

  logic        clk = 1'b0, rst_n = 1'b0, ext_clk = 1'b0;
  logic        halt = 1'b0, en_wr = 1'b0, en_val = 1'b0, rst_state = 1'b0;
  logic        wr = 1'b0, load = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [2:0]  wr_port = '0;
  logic [31:0] wr_dwell = '0;
  logic [4:0]  load_len = '0;
  logic [4:0]  sw_ctrl;
  logic [3:0]  act_idx;
  logic        cfg_err;

  ant_dwell_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext_clk), .halt_i(halt),
    .en_wr_i(en_wr), .en_val_i(en_val), .rst_state_i(rst_state),
    .wr_i(wr), .wr_idx_i(wr_idx), .wr_port_i(wr_port), .wr_dwell_i(wr_dwell),
    .load_i(load), .load_len_i(load_len),
    .sw_ctrl_o(sw_ctrl), .active_idx_o(act_idx), .cfg_err_o(cfg_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  initial forever begin
    repeat (2) @(negedge clk);
    ext_clk = ~ext_clk;
  end

  typedef struct { logic [3:0] idx; logic [4:0] ctrl; int len; } item_t;
  item_t sb_q[$];
  int    n_tests = 0, n_fail = 0;
  int    sp[16], sd[16];
  bit    mon_on = 1'b0, done = 1'b0;

  function automatic logic [4:0] enc(input int p);
    logic [2:0] b = p[2:0];
    return {~b[2], b[1], b[1], b[0], b[0]};
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_wr(input int i, input int p, input logic [31:0] d);
    @(negedge clk); wr = 1; wr_idx = 4'(i); wr_port = 3'(p); wr_dwell = d;
    @(negedge clk); wr = 0;
  endtask
  task automatic pulse_load(input int n);
    @(negedge clk); load = 1; load_len = 5'(n);
    @(negedge clk); load = 0;
  endtask
  task automatic pulse_en(input bit v);
    @(negedge clk); en_wr = 1; en_val = v;
    @(negedge clk); en_wr = 0;
  endtask
  task automatic pulse_rewind();
    @(negedge clk); rst_state = 1;
    @(negedge clk); rst_state = 0;
  endtask

  // driver: expected segments from entry 1 onward
  task automatic run_sb(input int n, input int loops);
    for (int k = 1; k <= n * loops; k++) begin
      int e = k % n;
      sb_q.push_back('{idx: 4'(e), ctrl: enc(sp[e]), len: sd[e] * STEP_CYC});
    end
    @(negedge clk); mon_on = 1; halt = 0;
    while (sb_q.size() > 0) @(negedge clk);
    repeat (STEP_CYC * 2) @(negedge clk);
    halt = 1; mon_on = 0;
    repeat (3) @(negedge clk);
  endtask

  // monitor
  logic [8:0] last_obs;
  int         seg_len;
  bit         have_pend;
  item_t      pend;
  always @(negedge clk) begin
    if (!mon_on) begin
      last_obs  = {act_idx, sw_ctrl};
      seg_len   = 0;
      have_pend = 0;
    end else begin
      seg_len++;
      if ({act_idx, sw_ctrl} != last_obs) begin
        if (have_pend) check(seg_len == pend.len, "R2", "dwell cycles", seg_len, pend.len);
        if (sb_q.size() > 0) begin
          pend = sb_q.pop_front();
          check(act_idx == pend.idx, "R3", "next index", int'(act_idx), int'(pend.idx));
          check(sw_ctrl == pend.ctrl, "R4", "switch lines", int'(sw_ctrl), int'(pend.ctrl));
          have_pend = 1;
        end else have_pend = 0;
        seg_len = 0;
      end
      last_obs = {act_idx, sw_ctrl};
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [8:0] snap;
    bit moved;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(sw_ctrl == 5'b10000, "R1", "reset lines", int'(sw_ctrl), 16);
    check(act_idx == 0, "R1", "reset index", int'(act_idx), 0);
    check(cfg_err == 0, "R1", "reset err", int'(cfg_err), 0);

    // schedule A
    sp[0] = 5; sd[0] = 3; sp[1] = 2; sd[1] = 1; sp[2] = 7; sd[2] = 2; sp[3] = 2; sd[3] = 4;
    halt = 1;
    for (int i = 0; i < 4; i++) pulse_wr(i, sp[i], 32'(sd[i]));
    pulse_load(4);
    repeat (2) @(negedge clk);
    check(sw_ctrl == enc(5), "R5", "load lines", int'(sw_ctrl), int'(enc(5)));
    check(act_idx == 0, "R5", "load index", int'(act_idx), 0);
    check(cfg_err == 0, "R10", "accepted err", int'(cfg_err), 0);
    pulse_en(1);
    run_sb(4, 3);

    // R8 halt freeze
    snap = {act_idx, sw_ctrl};
    repeat (200) @(negedge clk);
    check({act_idx, sw_ctrl} == snap, "R8", "halted state", int'({act_idx, sw_ctrl}), int'(snap));

    // R6 writes while running ignored
    halt = 0;
    pulse_en(0);
    pulse_wr(0, 0, 32'd9);
    pulse_load(1);
    snap = {act_idx, sw_ctrl}; moved = 0;
    repeat (200) begin @(negedge clk); if ({act_idx, sw_ctrl} != snap) moved = 1; end
    check(moved, "R6", "enable write ignored", int'(moved), 1);
    halt = 1;
    pulse_rewind();
    @(negedge clk);
    check(act_idx == 0, "R9", "rewind index", int'(act_idx), 0);
    check(sw_ctrl == enc(5), "R6", "schedule untouched", int'(sw_ctrl), int'(enc(5)));
    run_sb(4, 2);  // R9 schedule kept after rewind

    // R7 disabled hold
    pulse_en(0);
    halt = 0;
    snap = {act_idx, sw_ctrl};
    repeat (300) @(negedge clk);
    check({act_idx, sw_ctrl} == snap, "R7", "disabled hold", int'({act_idx, sw_ctrl}), int'(snap));
    halt = 1;

    // R10 rejects
    snap = {act_idx, sw_ctrl};
    pulse_load(0); @(negedge clk);
    check(cfg_err == 1, "R10", "zero length err", int'(cfg_err), 1);
    check({act_idx, sw_ctrl} == snap, "R10", "zero length outputs", int'({act_idx, sw_ctrl}), int'(snap));
    pulse_load(17); @(negedge clk);
    check(cfg_err == 1, "R10", "oversize err", int'(cfg_err), 1);
    pulse_wr(1, 3, 32'd0);
    pulse_load(4); @(negedge clk);
    check(cfg_err == 1, "R10", "zero dwell err", int'(cfg_err), 1);
    pulse_wr(0, 1, 32'hFFFF_FFFF);
    pulse_wr(1, 1, 32'h0000_0001);
    pulse_load(2); @(negedge clk);
    check(cfg_err == 1, "R10", "overflow err", int'(cfg_err), 1);
    pulse_rewind(); @(negedge clk);
    check(sw_ctrl == enc(5), "R10", "old schedule kept", int'(sw_ctrl), int'(enc(5)));

    // schedule B
    sp[0] = 0; sd[0] = 2; sp[1] = 6; sd[1] = 1;
    pulse_wr(0, sp[0], 32'(sd[0]));
    pulse_wr(1, sp[1], 32'(sd[1]));
    pulse_load(2);
    repeat (2) @(negedge clk);
    check(cfg_err == 0, "R10", "err cleared", int'(cfg_err), 0);
    check(sw_ctrl == enc(0), "R5", "reload lines", int'(sw_ctrl), int'(enc(0)));
    check(act_idx == 0, "R5", "reload index", int'(act_idx), 0);
    pulse_en(1);
    run_sb(2, 4);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule